// File: doc/BRIEF.md
# Edge-Selectable Input Counter Bank

The block counts transitions on a set of asynchronous digital input lines, with one counter per line. Each line first crosses into the system clock domain through a two-stage synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. On each qualifying transition the channel's counter advances by one. The host sets, per channel, whether rising edges, falling edges, both or neither count.

A simple synchronous register port gives the host its access. Counter addresses are read-only. One address holds the packed edge-mode field of every channel, and a write-only command address clears any chosen set of counters in a single write. Reads are registered, so the returned word is a snapshot of the counter taken in one clock cycle.

Top module: `edge_counter_bank`

## Requirements
- R1: After reset every counter reads 0 and the mode register reads 0. A read of address i, for i from 0 to 15, returns counter i zero-extended to 32 bits.
- R2: Each input passes through two synchronizer flops and one history flop. After an input change set up before rising edge k, the counter changes at edge k+2. A read whose strobe is sampled at edge k+2 still returns the old value, and one sampled at edge k+3 returns the new value.
- R3: The mode register is at address 16, and channel i uses bits [2i+1:2i]. The codes are 00 off, 01 rising edges only, 10 falling edges only and 11 both edges. A write to address 16 replaces the whole field, and a read of address 16 returns it.
- R4: On each transition that qualifies under its channel's mode, a counter increases by exactly one. A channel whose mode is 00 does not change.
- R5: A write to address 17 clears counter i when bit i of the write data is 1. It leaves the counters whose bits are 0 untouched.
- R6: A clear and a qualifying transition that take effect at the same clock edge leave the counter at 0.
- R7: A counter wraps from all-ones to zero and keeps counting. It does not saturate.
- R8: Read data appears on the clock edge that samples the read strobe. A read of address 17, or of any address above 17, returns 0.
- R9: Writes to counter addresses 0 to 15 have no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Asynchronous input lines, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A change on an input becomes visible in its counter three rising edges later. The bench therefore checks timing by issuing reads on three consecutive cycles right after an edge: the first two must return the old count and the third the new one. Read data is due one edge after the strobe. The driver queues the expected word at that point, and the monitor pops it at the falling edge after the next rising edge. For the clear-priority check, the clear write is placed in the cycle that ends at the increment edge. Wrap-around is checked on a narrow second instance, where the counter is 3 bits wide.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    function automatic logic edge_hit(edge_mode_e m, logic cur, logic prv);
        logic r;
        case (m)
            EDGE_RISE: r = cur & ~prv;
            EDGE_FALL: r = ~cur & prv;
            EDGE_BOTH: r = cur ^ prv;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ecb_sync.sv
module ecb_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/ecb_channel.sv
module ecb_channel
    import ecb_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,
    input  edge_mode_e    mode,
    input  logic          clr,
    output logic [CW-1:0] count
);
    logic          prev_q;
    logic          hit;
    logic [CW-1:0] cnt_q;

    assign hit = edge_hit(mode, lvl, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= lvl;
            if (clr) begin
                cnt_q <= '0;
            end else if (hit) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/ecb_regs.sv
module ecb_regs
    import ecb_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned CW  = 32,
    parameter int unsigned AW  = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [AW-1:0]            reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  logic [NCH-1:0][CW-1:0]   cnt,
    output edge_mode_e [NCH-1:0]     mode,
    output logic [NCH-1:0]           clr,
    output logic [DATA_W-1:0]        reg_rdata
);
    localparam int unsigned IW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int unsigned CFG_ADDR = NCH;
    localparam int unsigned CLR_ADDR = NCH + 1;

    edge_mode_e [NCH-1:0] cfg_q;
    logic [DATA_W-1:0]    rd_next;
    logic [DATA_W-1:0]    rdata_q;
    logic                 hit_cfg;
    logic                 hit_clr;
    logic                 hit_cnt;

    assign hit_cfg = (reg_addr == AW'(CFG_ADDR));
    assign hit_clr = (reg_addr == AW'(CLR_ADDR));
    assign hit_cnt = (reg_addr < AW'(NCH));

    assign clr = (reg_wr && hit_clr) ? reg_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{default: EDGE_OFF};
        end else if (reg_wr && hit_cfg) begin
            for (int i = 0; i < NCH; i++) begin
                cfg_q[i] <= edge_mode_e'(reg_wdata[2*i +: 2]);
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit_cnt) begin
            rd_next[CW-1:0] = cnt[reg_addr[IW-1:0]];
        end else if (hit_cfg) begin
            for (int i = 0; i < NCH; i++) begin
                rd_next[2*i +: 2] = cfg_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign mode      = cfg_q;
    assign reg_rdata = rdata_q;
endmodule

// File: rtl/edge_counter_bank.sv
module edge_counter_bank
    import ecb_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned CW  = 32,
    parameter int unsigned AW  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    din,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [NCH-1:0]         lvl_vec;
    logic [NCH-1:0]         clr_vec;
    edge_mode_e [NCH-1:0]   mode_vec;
    logic [NCH-1:0][CW-1:0] cnt_vec;

    ecb_sync #(.W(NCH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (lvl_vec)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ecb_channel #(.CW(CW)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .lvl   (lvl_vec[g]),
            .mode  (mode_vec[g]),
            .clr   (clr_vec[g]),
            .count (cnt_vec[g])
        );
    end

    ecb_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt       (cnt_vec),
        .mode      (mode_vec),
        .clr       (clr_vec),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker #(
    parameter int unsigned NCH = 16,
    parameter int unsigned CW  = 32,
    parameter int unsigned AW  = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         clr,
    input logic [NCH-1:0][1:0]    mode,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic                   reg_rd,
    input logic [AW-1:0]          reg_addr,
    input logic [31:0]            reg_rdata
);
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [IW-1:0] ridx;
    assign ridx = reg_addr[IW-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R6
        clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
            clr[g] |=> (cnt[g] == '0));

        // R4
        step_one_chk: assert property (@(posedge clk) disable iff (rst)
            !clr[g] |=> (CW'(cnt[g] - $past(cnt[g])) <= CW'(1)));

        // R3
        off_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == 2'b00 && !clr[g]) |=> $stable(cnt[g]));
    end

    // R8
    read_snap_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr < AW'(NCH)) |=> (reg_rdata[CW-1:0] == $past(cnt[ridx])));
endmodule

bind edge_counter_bank ecb_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_ecb_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_vec),
    .mode      (mode_vec),
    .cnt       (cnt_vec),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/edge_counter_bank_bench.sv
`timescale 1ns/1ps
module edge_counter_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    logic [1:0]  n_din = '0;
    logic        n_wr = 1'b0;
    logic        n_rd = 1'b0;
    logic [4:0]  n_addr = '0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    edge_counter_bank u_edge_counter_bank (
        .clk(clk), .rst(rst), .din(din), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    edge_counter_bank #(.NCH(2), .CW(3), .AW(5)) u_edge_counter_bank_narrow (
        .clk(clk), .rst(rst), .din(n_din), .reg_wr(n_wr), .reg_rd(n_rd),
        .reg_addr(n_addr), .reg_wdata(n_wdata), .reg_rdata(n_rdata));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(logic [4:0] a, logic [31:0] e, string tag);
        reg_rd = 1'b1;
        reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_write(logic [4:0] a, logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(logic [15:0] m, int n);
        for (int i = 0; i < n; i++) begin
            din = din ^ m;
            idle(4);
            din = din ^ m;
            idle(4);
        end
    endtask

    task automatic n_read(logic [4:0] a, logic [31:0] e, string tag);
        n_rd = 1'b1;
        n_addr = a;
        @(negedge clk);
        n_rd = 1'b0;
        chk(tag, n_rdata, e);
    endtask

    // monitor: pops one expected word per read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (reg_rd) begin
                @(negedge clk);
                chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #1ms;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        for (int i = 0; i < 16; i++) do_read(5'(i), 32'h0, "R1 counter after reset");
        do_read(5'd16, 32'h0, "R1 mode after reset");
        // R3 mode off: toggles ignored
        pulses(16'h0001, 3);
        idle(3);
        do_read(5'd0, 32'h0, "R3 off mode ignores edges");
        // R3 configure: ch0 rise, ch1 fall, ch2 both, rest off
        do_write(5'd16, 32'h0000_0039);
        do_read(5'd16, 32'h0000_0039, "R3 mode readback");
        pulses(16'h001F, 5);
        idle(3);
        do_read(5'd0, 32'd5, "R4 rising count");
        do_read(5'd1, 32'd5, "R4 falling count");
        do_read(5'd2, 32'd10, "R4 both-edge count");
        do_read(5'd3, 32'd0, "R3 ch3 off");
        do_read(5'd4, 32'd0, "R3 ch4 off");
        // R2 latency
        din[0] = 1'b1;
        idle(1);
        do_read(5'd0, 32'd5, "R2 not yet k+1");
        do_read(5'd0, 32'd5, "R2 not yet k+2");
        do_read(5'd0, 32'd6, "R2 visible k+3");
        din[0] = 1'b0;
        idle(4);
        // R5 masked clear
        do_write(5'd17, 32'h0000_0002);
        do_read(5'd1, 32'd0, "R5 cleared channel");
        do_read(5'd2, 32'd10, "R5 untouched channel");
        do_read(5'd0, 32'd6, "R5 untouched ch0");
        // R9 write to counter address ignored
        do_write(5'd2, 32'hFFFF_FFFF);
        do_read(5'd2, 32'd10, "R9 counter write ignored");
        // R8 unmapped and clear address read zero
        do_read(5'd17, 32'h0, "R8 clear address reads 0");
        do_read(5'd20, 32'h0, "R8 unmapped reads 0");
        // R6 clear wins over same-edge increment
        din[0] = 1'b1;
        idle(2);
        do_write(5'd17, 32'h0000_0001);
        idle(3);
        do_read(5'd0, 32'd0, "R6 clear priority");
        din[0] = 1'b0;
        idle(4);
        pulses(16'h0001, 2);
        idle(3);
        do_read(5'd0, 32'd2, "R4 counting after clear");
        // R7 wrap on narrow instance (3-bit counters, ch0 both edges)
        n_wr = 1'b1; n_addr = 5'd2; n_wdata = 32'h3;
        @(negedge clk);
        n_wr = 1'b0;
        for (int i = 0; i < 7; i++) begin n_din[0] = ~n_din[0]; idle(3); end
        idle(3);
        n_read(5'd0, 32'd7, "R7 all-ones reached");
        for (int i = 0; i < 2; i++) begin n_din[0] = ~n_din[0]; idle(3); end
        idle(3);
        n_read(5'd0, 32'd1, "R7 wrapped past zero");
        idle(3);
        while (exp_q.size() != 0) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule